// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Sequencer

This block sits beside a processor core's debug comparators and turns their match pulses into a debug response. Software arms it through a small two-register configuration port. One register is the trigger-definition register. It holds the level-1 source mask, the response choice and an arm bit. The other is the extended register. It holds the level-2 enable and the level-2 source mask. Once armed, the block walks a one- or two-level trigger sequence. It reports its progress as a coded status field and as a trace nibble for the external trace port.

When the sequence completes, the block acts on the configured response. It can ask the core to halt, which it shows with processor status code 0xF. It can raise a debug interrupt, which ranks above every maskable and non-maskable source. It can also just record the event. A program-counter trigger is taken precisely: it is recognised at the very sample point that carries the match, before the instruction runs. Address and data triggers wait for a later instruction sample point. The two kinds use different vector numbers. Recognition is shown by status code 0xD for a fixed number of cycles, and the core acknowledges the interrupt afterwards.

Top module: `brkpt_seq`

## Requirements
- R1: The status field only ever takes one of five codes: 0000 idle, 0001 waiting for level 1, 0010 level 1 fired, 0101 waiting for level 2, 0110 level 2 fired. After reset it reads 0000.
- R2: The trace nibble follows the status field with this mapping: 0000→0000, 0001→0010, 0010→0100, 0101→1010, 0110→1100.
- R3: In the waiting-for-level-1 state, a match counts only on a source whose bit is set in the level-1 mask. Source bit 0 is the PC comparator, bit 1 the address comparator and bit 2 the data comparator. A match counts on the cycle it is seen, and the status changes on the next cycle. Matches on unmasked sources leave the status unchanged.
- R4: With level 2 enabled, a level-1 match moves the status to 0101 and produces no response. Only a later match on a level-2-masked source moves it to 0110 and produces the response.
- R5: A CSR read sets the status to 0000 when it is 0110, or when it is 0010 with level 2 disabled. A CSR read has no effect in the waiting states.
- R6: Any write to either configuration register clears the status. A trigger-definition write (cfg_ext=0) has this field layout: bit 0 arm, bits NUM_SRC:1 level-1 mask, the next two bits the response. It moves the status to 0001 if arm is set and the mask is non-zero, else to 0000. An extended write (cfg_ext=1) has this field layout: bit 0 level-2 enable, bits NUM_SRC:1 level-2 mask. It leaves the block disarmed at 0000.
- R7: With response 01, halt_req is high and pst reads 0xF while the status is 0010 or 0110.
- R8: With response 10, a fired trigger raises dbg_irq on the next cycle. dbg_vec is 13 when the firing match included the PC source, else 12. dbg_vec reads 0 while dbg_irq is low.
- R9: A PC-source debug interrupt whose match coincides with insn_sample is recognised at once. Any other debug interrupt stays pending, with pst unchanged, until a later insn_sample.
- R10: From the cycle after recognition, pst reads 0xD for exactly EXC_CYCLES cycles, then returns to the run code 0x0.
- R11: irq_ack is ignored while the interrupt is pending or the 0xD window is running. After the window, irq_ack clears dbg_irq on the next cycle.
- R12: Response codes 00 and 11 record status only: halt_req and dbg_irq stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_match | input | NUM_SRC | Comparator match pulses (bit 0 PC, 1 address, 2 data) |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_ext | input | 1 | Register select: 0 trigger-definition, 1 extended |
| cfg_data | input | NUM_SRC+3 | Write data |
| csr_rd | input | 1 | Status register read strobe |
| insn_sample | input | 1 | Per-instruction interrupt sample point |
| irq_ack | input | 1 | Core acknowledge of the debug interrupt |
| bstat | output | 4 | Breakpoint status code |
| trace_nib | output | 4 | Trace nibble matching the status |
| halt_req | output | 1 | Core halt request |
| pst | output | PST_W | Processor status code |
| dbg_irq | output | 1 | Debug interrupt request |
| dbg_vec | output | VEC_W | Debug interrupt vector number |

## Verification
The bench builds the block with three comparator sources, EXC_CYCLES of 3 and TRACE_REG set to 1. The registered trace variant is therefore checked at the ports, while the default elaboration covers the combinational one. With three sources, the bench can use a PC-only level-1 mask against a data-only level-2 mask. It can also show a masked-out data match being ignored. A three-cycle exception window is long enough to land an acknowledge inside it, where it must be ignored, and then one just after it closes.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE = 4'b0000,
      ST_ARM1 = 4'b0001,
      ST_HIT1 = 4'b0010,
      ST_ARM2 = 4'b0101,
      ST_HIT2 = 4'b0110
   } bstat_e;

   typedef enum logic [1:0] {
      RSP_NONE = 2'b00,
      RSP_HALT = 2'b01,
      RSP_IRQ  = 2'b10,
      RSP_RSVD = 2'b11
   } resp_e;

   // trace nibble attached to each status code (R2)
   function automatic logic [3:0] trace_code(bstat_e s);
      case (s)
         ST_ARM1: return 4'b0010;
         ST_HIT1: return 4'b0100;
         ST_ARM2: return 4'b1010;
         ST_HIT2: return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/brkpt_level_fsm.sv
module brkpt_level_fsm
   import brkpt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   arm_load,
   input  logic   arm_ok,
   input  logic   disarm,
   input  logic   l2_en,
   input  logic   l1_hit,
   input  logic   l2_hit,
   input  logic   csr_rd,
   output bstat_e state,
   output bstat_e state_nx,
   output logic   fire
);

   always_comb begin
      state_nx = state;
      fire     = 1'b0;
      if (arm_load) begin
         state_nx = arm_ok ? ST_ARM1 : ST_IDLE;
      end else if (disarm) begin
         state_nx = ST_IDLE;
      end else begin
         case (state)
            ST_ARM1: if (l1_hit) begin
               if (l2_en) begin
                  state_nx = ST_ARM2;
               end else begin
                  state_nx = ST_HIT1;
                  fire     = 1'b1;
               end
            end
            ST_ARM2: if (l2_hit) begin
               state_nx = ST_HIT2;
               fire     = 1'b1;
            end
            ST_HIT1: if (csr_rd && !l2_en) state_nx = ST_IDLE;
            ST_HIT2: if (csr_rd) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state inside {ST_IDLE, ST_ARM1, ST_HIT1, ST_ARM2, ST_HIT2});

   assert_l2_via_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HIT2) |-> ($past(state) == ST_ARM2 || $past(state) == ST_HIT2));

   assert_csr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && !arm_load && !disarm && state == ST_HIT2) |=> (state == ST_IDLE));

endmodule

// File: rtl/brkpt_irq_ctl.sv
module brkpt_irq_ctl #(
   parameter int EXC_CYCLES = 3,
   parameter int VEC_W      = 8,
   parameter int VEC_PC     = 13,
   parameter int VEC_BUS    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raise,
   input  logic             raise_pc,
   input  logic             sample,
   input  logic             ack,
   output logic             irq,
   output logic [VEC_W-1:0] vec,
   output logic             exc_active
);

   localparam int CW = $clog2(EXC_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(EXC_CYCLES);

   logic          irq_q, pend_q, pc_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         pend_q <= 1'b0;
         pc_q   <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
         if (raise && !irq_q) begin
            irq_q <= 1'b1;
            pc_q  <= raise_pc;
            if (sample && raise_pc) begin
               pend_q <= 1'b0;
               cnt_q  <= CNT_LOAD;
            end else begin
               pend_q <= 1'b1;
            end
         end else if (pend_q && sample) begin
            pend_q <= 1'b0;
            cnt_q  <= CNT_LOAD;
         end else if (irq_q && !pend_q && cnt_q == '0 && ack) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq        = irq_q;
   assign vec        = irq_q ? (pc_q ? VEC_W'(VEC_PC) : VEC_W'(VEC_BUS)) : '0;
   assign exc_active = (cnt_q != '0);

   assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !sample) |=> pend_q);

   assert_window_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && sample) |=> (exc_active && irq_q));

   assert_ack_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && (pend_q || cnt_q != '0)) |=> irq_q);

endmodule

// File: rtl/brkpt_seq.sv
module brkpt_seq
   import brkpt_pkg::*;
#(
   parameter int NUM_SRC    = 3,
   parameter int PC_IDX     = 0,
   parameter int EXC_CYCLES = 3,
   parameter int VEC_W      = 8,
   parameter int VEC_PC     = 13,
   parameter int VEC_BUS    = 12,
   parameter int PST_W      = 4,
   parameter logic [PST_W-1:0] PST_RUN  = 'h0,
   parameter logic [PST_W-1:0] PST_HALT = 'hF,
   parameter logic [PST_W-1:0] PST_EXC  = 'hD,
   parameter bit TRACE_REG  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_match,
   input  logic               cfg_wr,
   input  logic               cfg_ext,
   input  logic [NUM_SRC+2:0] cfg_data,
   input  logic               csr_rd,
   input  logic               insn_sample,
   input  logic               irq_ack,
   output logic [3:0]         bstat,
   output logic [3:0]         trace_nib,
   output logic               halt_req,
   output logic [PST_W-1:0]   pst,
   output logic               dbg_irq,
   output logic [VEC_W-1:0]   dbg_vec
);

   localparam int RSP_LSB = NUM_SRC + 1;

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || PC_IDX < 0 || PC_IDX >= NUM_SRC) begin : g_bad_src
      $error("brkpt_seq: PC_IDX must index one of NUM_SRC sources");
   end
   if (EXC_CYCLES < 1) begin : g_bad_exc
      $error("brkpt_seq: EXC_CYCLES must be at least 1");
   end
   if (VEC_PC >= (1 << VEC_W) || VEC_BUS >= (1 << VEC_W) || VEC_PC == VEC_BUS) begin : g_bad_vec
      $error("brkpt_seq: vectors must be distinct and fit VEC_W");
   end

   logic [NUM_SRC-1:0] l1_mask_q, l2_mask_q;
   logic               l2_en_q;
   resp_e              resp_q;

   wire def_wr = cfg_wr && !cfg_ext;
   wire ext_wr = cfg_wr &&  cfg_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l1_mask_q <= '0;
         l2_mask_q <= '0;
         l2_en_q   <= 1'b0;
         resp_q    <= RSP_NONE;
      end else if (def_wr) begin
         l1_mask_q <= cfg_data[NUM_SRC:1];
         resp_q    <= resp_e'(cfg_data[RSP_LSB +: 2]);
      end else if (ext_wr) begin
         l2_en_q   <= cfg_data[0];
         l2_mask_q <= cfg_data[NUM_SRC:1];
      end
   end

   logic [NUM_SRC-1:0] l1_vec, l2_vec;
   assign l1_vec = src_match & l1_mask_q;
   assign l2_vec = src_match & l2_mask_q;

   bstat_e state, state_nx;
   logic   fire;

   brkpt_level_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_load (def_wr),
      .arm_ok   (cfg_data[0] && (cfg_data[NUM_SRC:1] != '0)),
      .disarm   (ext_wr),
      .l2_en    (l2_en_q),
      .l1_hit   (|l1_vec),
      .l2_hit   (|l2_vec),
      .csr_rd   (csr_rd),
      .state    (state),
      .state_nx (state_nx),
      .fire     (fire)
   );

   wire fire_pc = (state == ST_ARM2) ? l2_vec[PC_IDX] : l1_vec[PC_IDX];
   logic exc_active;

   brkpt_irq_ctl #(
      .EXC_CYCLES (EXC_CYCLES),
      .VEC_W      (VEC_W),
      .VEC_PC     (VEC_PC),
      .VEC_BUS    (VEC_BUS)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .raise      (fire && resp_q == RSP_IRQ),
      .raise_pc   (fire_pc),
      .sample     (insn_sample),
      .ack        (irq_ack),
      .irq        (dbg_irq),
      .vec        (dbg_vec),
      .exc_active (exc_active)
   );

   assign bstat    = state;
   assign halt_req = (resp_q == RSP_HALT) && (state == ST_HIT1 || state == ST_HIT2);
   assign pst      = exc_active ? PST_EXC : (halt_req ? PST_HALT : PST_RUN);

   if (TRACE_REG) begin : g_trace_reg
      logic [3:0] trace_q;
      always_ff @(posedge clk) begin
         if (!rst_n) trace_q <= 4'b0000;
         else        trace_q <= trace_code(state_nx);
      end
      assign trace_nib = trace_q;
   end else begin : g_trace_comb
      assign trace_nib = trace_code(state);
   end

   assert_halt_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> (pst == PST_HALT));

   assert_vec_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq |-> (dbg_vec == VEC_W'(VEC_PC) || dbg_vec == VEC_W'(VEC_BUS)));

   assert_quiet_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (resp_q == RSP_NONE || resp_q == RSP_RSVD) && !dbg_irq) |=> !dbg_irq);

endmodule

// File: tb/test_brkpt_seq.sv
module test_brkpt_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] src_match = '0;
   logic       cfg_wr = 1'b0, cfg_ext = 1'b0;
   logic [5:0] cfg_data = '0;
   logic       csr_rd = 1'b0, insn_sample = 1'b0, irq_ack = 1'b0;
   logic [3:0] bstat, trace_nib, pst;
   logic       halt_req, dbg_irq;
   logic [7:0] dbg_vec;

   always #4 clk = ~clk;

   brkpt_seq #(.NUM_SRC(3), .EXC_CYCLES(3), .TRACE_REG(1'b1)) i_brkpt_seq (
      .clk(clk), .rst_n(rst_n), .src_match(src_match), .cfg_wr(cfg_wr),
      .cfg_ext(cfg_ext), .cfg_data(cfg_data), .csr_rd(csr_rd),
      .insn_sample(insn_sample), .irq_ack(irq_ack), .bstat(bstat),
      .trace_nib(trace_nib), .halt_req(halt_req), .pst(pst),
      .dbg_irq(dbg_irq), .dbg_vec(dbg_vec)
   );

   typedef struct packed {
      logic [3:0] st;
      logic [3:0] tr;
      logic       halt;
      logic [3:0] pst;
      logic       irq;
      logic [7:0] vec;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   function automatic logic [3:0] nib_of(logic [3:0] s);
      case (s)
         4'b0001: return 4'b0010;
         4'b0010: return 4'b0100;
         4'b0101: return 4'b1010;
         4'b0110: return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [5:0] defw(logic arm, logic [2:0] mask, logic [1:0] rsp);
      return {rsp, mask, arm};
   endfunction

   function automatic logic [5:0] extw(logic en, logic [2:0] mask);
      return {2'b00, mask, en};
   endfunction

   // driver: one clock of stimulus
   task automatic drive(input logic [2:0] m, input logic w, input logic x,
                        input logic [5:0] d, input logic c, input logic s, input logic a);
      @(negedge clk);
      src_match = m; cfg_wr = w; cfg_ext = x; cfg_data = d;
      csr_rd = c; insn_sample = s; irq_ack = a;
      @(posedge clk);
      #1;
      src_match = '0; cfg_wr = 1'b0; cfg_ext = 1'b0; cfg_data = '0;
      csr_rd = 1'b0; insn_sample = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic idle();
      drive(3'b000, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0);
   endtask

   // push the expected port state after the last driven clock
   task automatic expect_st(input string tag, input logic [3:0] st, input logic h,
                            input logic [3:0] p, input logic i, input logic [7:0] v);
      exp_t e;
      e.st = st; e.tr = nib_of(st); e.halt = h; e.pst = p; e.irq = i; e.vec = v;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compare at the falling edge after each pushed item
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() != 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {bstat, trace_nib, halt_req, pst, dbg_irq, dbg_vec};
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s: got st=%b tr=%b halt=%b pst=%h irq=%b vec=%0d exp st=%b tr=%b halt=%b pst=%h irq=%b vec=%0d",
                        t, a.st, a.tr, a.halt, a.pst, a.irq, a.vec,
                        e.st, e.tr, e.halt, e.pst, e.irq, e.vec);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();                                  expect_st("R1 reset", 4'b0000, 0, 4'h0, 0, 8'd0);
      // single level, address source, record only
      drive(3'b000, 1, 0, defw(1, 3'b010, 2'b00), 0, 0, 0);
                                               expect_st("R6 R2 arm", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b100, 0, 0, 6'd0, 0, 0, 0);      expect_st("R3 unmasked", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 read while waiting", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b010, 0, 0, 6'd0, 0, 0, 0);      expect_st("R3 R12 level1", 4'b0010, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 read clears", 4'b0000, 0, 4'h0, 0, 8'd0);
      // two levels, PC then data, halt response
      drive(3'b000, 1, 1, extw(1, 3'b100), 0, 0, 0);
                                               expect_st("R6 ext write", 4'b0000, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 1, 0, defw(1, 3'b001, 2'b01), 0, 0, 0);
                                               expect_st("R6 arm2", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b001, 0, 0, 6'd0, 0, 0, 0);      expect_st("R4 to wait2", 4'b0101, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 read in wait2", 4'b0101, 0, 4'h0, 0, 8'd0);
      drive(3'b001, 0, 0, 6'd0, 0, 0, 0);      expect_st("R4 level1 src ignored", 4'b0101, 0, 4'h0, 0, 8'd0);
      drive(3'b100, 0, 0, 6'd0, 0, 0, 0);      expect_st("R4 R7 level2", 4'b0110, 1, 4'hF, 0, 8'd0);
      idle();                                  expect_st("R7 halt held", 4'b0110, 1, 4'hF, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 R7 read clears", 4'b0000, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 1, 0, defw(1, 3'b001, 2'b01), 0, 0, 0);
                                               expect_st("R6 rearm", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 1, 1, extw(0, 3'b000), 0, 0, 0);
                                               expect_st("R6 ext disarms", 4'b0000, 0, 4'h0, 0, 8'd0);
      drive(3'b001, 0, 0, 6'd0, 0, 0, 0);      expect_st("R6 no trigger", 4'b0000, 0, 4'h0, 0, 8'd0);
      // imprecise data trigger, interrupt response
      drive(3'b000, 1, 0, defw(1, 3'b100, 2'b10), 0, 0, 0);
                                               expect_st("R6 arm irq", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b100, 0, 0, 6'd0, 0, 1, 0);      expect_st("R8 R9 bus pending", 4'b0010, 0, 4'h0, 1, 8'd12);
      idle();                                  expect_st("R9 still pending", 4'b0010, 0, 4'h0, 1, 8'd12);
      drive(3'b000, 0, 0, 6'd0, 0, 0, 1);      expect_st("R11 ack while pending", 4'b0010, 0, 4'h0, 1, 8'd12);
      drive(3'b000, 0, 0, 6'd0, 0, 1, 0);      expect_st("R10 window 1", 4'b0010, 0, 4'hD, 1, 8'd12);
      drive(3'b000, 0, 0, 6'd0, 0, 0, 1);      expect_st("R10 R11 window 2", 4'b0010, 0, 4'hD, 1, 8'd12);
      idle();                                  expect_st("R10 window 3", 4'b0010, 0, 4'hD, 1, 8'd12);
      idle();                                  expect_st("R10 window end", 4'b0010, 0, 4'h0, 1, 8'd12);
      drive(3'b000, 0, 0, 6'd0, 0, 0, 1);      expect_st("R11 ack clears", 4'b0010, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 read level1 no l2", 4'b0000, 0, 4'h0, 0, 8'd0);
      // precise PC trigger
      drive(3'b000, 1, 0, defw(1, 3'b001, 2'b10), 0, 0, 0);
                                               expect_st("R6 arm pc", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b001, 0, 0, 6'd0, 0, 1, 0);      expect_st("R8 R9 pc precise", 4'b0010, 0, 4'hD, 1, 8'd13);
      idle();                                  expect_st("R10 pc window 2", 4'b0010, 0, 4'hD, 1, 8'd13);
      idle();                                  expect_st("R10 pc window 3", 4'b0010, 0, 4'hD, 1, 8'd13);
      idle();                                  expect_st("R10 pc window end", 4'b0010, 0, 4'h0, 1, 8'd13);
      drive(3'b000, 0, 0, 6'd0, 0, 0, 1);      expect_st("R11 pc ack", 4'b0010, 0, 4'h0, 0, 8'd0);
      // reserved response code
      drive(3'b000, 0, 0, 6'd0, 1, 0, 0);      expect_st("R5 clear", 4'b0000, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 1, 0, defw(1, 3'b010, 2'b11), 0, 0, 0);
                                               expect_st("R6 arm rsp11", 4'b0001, 0, 4'h0, 0, 8'd0);
      drive(3'b010, 0, 0, 6'd0, 0, 1, 0);      expect_st("R12 rsp11 fire", 4'b0010, 0, 4'h0, 0, 8'd0);
      drive(3'b000, 0, 0, 6'd0, 0, 1, 0);      expect_st("R12 rsp11 quiet", 4'b0010, 0, 4'h0, 0, 8'd0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule